// File: doc/BRIEF.md
# I2C Repeated Start Sequencer

This block is the part of an I2C master that produces a Repeated Start condition on the open-drain SDA and SCL lines. Software sets a request bit. If no other master event is running, the sequencer pulls SCL low, lets SDA float high, releases SCL, holds both lines high for one bit period, then pulls SDA low while SCL stays high. It leaves SDA held low for the address byte that follows. Every bit-period interval is timed by a down-counter loaded from a reload value. A phase moves on only after the synchronized pin level confirms that the line has reached the level the sequencer asked for.

While the sequence runs, the block guards the master. A write to the transmit buffer is refused and raises a write-collision flag. Writes to the event-control bits are blocked, so a second event cannot be queued. The sequencer watches the bus for another master. SDA found low when SCL is seen high, or SCL pulled low during the high-hold period, aborts the sequence: both lines are released, the request bit is cleared and a bus-collision flag is raised. Separate sticky flags report that a Start was seen on the pins and that the sequence completed.

The pin inputs reach the sequencer only through a two-flop synchronizer, and every flag and line drive is a register.

Top module: `i2c_rstart_seq`

## Requirements
- R1: A request (`req_set_i` high for one cycle) is taken only while `req_o` is 0 and `other_busy_i` is 0. A request made with `other_busy_i` high leaves `req_o`, `scl_drv_o` and `sda_drv_o` unchanged.
- R2: After the clock edge that takes a request, `req_o` is 1 and `scl_drv_o` is 1 (1 means the line is pulled low).
- R3: SCL is released only when two things are true: the SDA-released interval of reload+1 cycles has run out, and SDA is seen high. With lines that follow the drives, `scl_drv_o` falls reload+4 cycles after the accepting edge. At that point `sda_drv_o` is 0.
- R4: With lines that follow the drives and reload ≥ 2, `done_irq_o` rises exactly 3*reload+9 cycles after the accepting edge.
- R5: When the sequence completes, `req_o` clears, `sda_drv_o` stays 1 (SDA held low) and `scl_drv_o` is 0.
- R6: `start_det_o` is set when the synchronized SDA falls while the synchronized SCL is high. In a normal sequence this is 2*reload+11 cycles after the accepting edge, which is before `done_irq_o` when reload ≥ 3.
- R7: `done_irq_o` is set only by the final timeout of the SDA-low interval. It is not set when the Start is detected, and it is not set on a collision.
- R8: A buffer write (`buf_wr_i`) while `req_o` is 1 sets `wcol_o` and leaves `buf_o` unchanged. This includes the completion cycle. A write while idle loads `buf_o`.
- R9: If SDA is seen low at the moment SCL is seen high in the SCL-release phase, `bcol_o` is set, both drives are released and `req_o` clears. This happens 3 cycles after the external SDA pull begins at the SCL release.
- R10: If SCL is seen low during the high-hold interval, `bcol_o` is set, both drives are released and `req_o` clears. `done_irq_o` stays 0.
- R11: `evt_wr_i` loads `evt_bits_o` only while `req_o` is 0. It is ignored while a sequence runs.
- R12: `flag_clr_i` clears `start_det_o`, `done_irq_o`, `wcol_o` and `bcol_o`.
- R13: After reset, all outputs are 0.
- R14: The pin levels pass through a two-flop synchronizer. When SDA was left low by an earlier sequence, `sda_drv_o` is released 3 cycles after the accepting edge, once SCL has been seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set_i | input | 1 | Request pulse that sets the repeated-start request bit |
| other_busy_i | input | 1 | Another master event is in progress |
| reload_i | input | RLD_W | Bit-period reload value (interval = value+1 cycles) |
| sda_in_i | input | 1 | Raw SDA line level |
| scl_in_i | input | 1 | Raw SCL line level |
| buf_wr_i | input | 1 | Transmit buffer write strobe |
| buf_wdata_i | input | BUF_W | Transmit buffer write data |
| evt_wr_i | input | 1 | Event-control bits write strobe |
| evt_wdata_i | input | EVT_W | Event-control bits write data |
| flag_clr_i | input | 1 | Clears the four sticky flags |
| sda_drv_o | output | 1 | 1 pulls SDA low |
| scl_drv_o | output | 1 | 1 pulls SCL low |
| req_o | output | 1 | Request bit, clears itself at the end |
| start_det_o | output | 1 | Start seen on the pins |
| done_irq_o | output | 1 | Sequence completed |
| wcol_o | output | 1 | Buffer write refused |
| bcol_o | output | 1 | Bus collision |
| buf_o | output | BUF_W | Transmit buffer contents |
| evt_bits_o | output | EVT_W | Event-control bits |

## Verification
A buffer write and the completion of the sequence can fall on the same clock edge. The write must then count as a collision, because the sequence is still active at that edge, and `done_irq_o` must rise on the same edge. The bench computes that edge from the reload value (3*reload+9 after acceptance), puts a write on it, and expects `wcol_o` set, `buf_o` unchanged and the completion record matched by the scoreboard. A second write one cycle later must load the buffer.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  typedef enum logic [2:0] {
    RS_IDLE    = 3'd0,
    RS_SCL_DN  = 3'd1,
    RS_SDA_UP  = 3'd2,
    RS_SCL_UP  = 3'd3,
    RS_HOLD_HI = 3'd4,
    RS_SDA_DN  = 3'd5
  } rs_state_t;

  localparam int LINE_SDA = 0;
  localparam int LINE_SCL = 1;
  localparam int LINES    = 2;
endpackage

// File: rtl/rs_pin_sync.sv
module rs_pin_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) stg <= '1;
        else     stg <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) stg <= '1;
        else     stg <= {stg[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/rs_baud_cnt.sv
module rs_baud_cnt #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         busy_o,
  output logic         tout_o
);
  logic [W-1:0] cnt;
  logic         run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load_i) begin
      cnt <= val_i;
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign busy_o = run;
  assign tout_o = run && (cnt == '0);
endmodule

// File: rtl/rs_seq_fsm.sv
module rs_seq_fsm
  import i2c_rs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic sda_s_i,
  input  logic scl_s_i,
  input  logic tout_i,
  input  logic cnt_busy_i,
  output logic cnt_load_o,
  output logic done_o,
  output logic bcol_o,
  output logic active_o,
  output logic sda_drv_o,
  output logic scl_drv_o
);
  rs_state_t st, st_nx;
  logic      sda_nx, scl_nx;

  always_comb begin
    st_nx      = st;
    sda_nx     = sda_drv_o;
    scl_nx     = scl_drv_o;
    cnt_load_o = 1'b0;
    done_o     = 1'b0;
    bcol_o     = 1'b0;
    unique case (st)
      RS_IDLE: begin
        if (start_i) begin
          scl_nx = 1'b1;
          st_nx  = RS_SCL_DN;
        end
      end
      RS_SCL_DN: begin
        if (!scl_s_i) begin
          cnt_load_o = 1'b1;
          sda_nx     = 1'b0;
          st_nx      = RS_SDA_UP;
        end
      end
      RS_SDA_UP: begin
        if ((tout_i || !cnt_busy_i) && sda_s_i) begin
          scl_nx = 1'b0;
          st_nx  = RS_SCL_UP;
        end
      end
      RS_SCL_UP: begin
        if (scl_s_i) begin
          if (!sda_s_i) begin
            bcol_o = 1'b1;
          end else begin
            cnt_load_o = 1'b1;
            st_nx      = RS_HOLD_HI;
          end
        end
      end
      RS_HOLD_HI: begin
        if (!scl_s_i) begin
          bcol_o = 1'b1;
        end else if (tout_i) begin
          sda_nx     = 1'b1;
          cnt_load_o = 1'b1;
          st_nx      = RS_SDA_DN;
        end
      end
      RS_SDA_DN: begin
        if (tout_i) begin
          done_o = 1'b1;
          st_nx  = RS_IDLE;
        end
      end
      default: st_nx = RS_IDLE;
    endcase
    if (bcol_o) begin
      sda_nx = 1'b0;
      scl_nx = 1'b0;
      st_nx  = RS_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RS_IDLE;
      sda_drv_o <= 1'b0;
      scl_drv_o <= 1'b0;
    end else begin
      st        <= st_nx;
      sda_drv_o <= sda_nx;
      scl_drv_o <= scl_nx;
    end
  end

  assign active_o = (st != RS_IDLE);
endmodule

// File: rtl/i2c_rstart_seq.sv
module i2c_rstart_seq
  import i2c_rs_pkg::*;
#(
  parameter int RLD_W       = 7,
  parameter int BUF_W       = 8,
  parameter int EVT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_set_i,
  input  logic             other_busy_i,
  input  logic [RLD_W-1:0] reload_i,
  input  logic             sda_in_i,
  input  logic             scl_in_i,
  input  logic             buf_wr_i,
  input  logic [BUF_W-1:0] buf_wdata_i,
  input  logic             evt_wr_i,
  input  logic [EVT_W-1:0] evt_wdata_i,
  input  logic             flag_clr_i,
  output logic             sda_drv_o,
  output logic             scl_drv_o,
  output logic             req_o,
  output logic             start_det_o,
  output logic             done_irq_o,
  output logic             wcol_o,
  output logic             bcol_o,
  output logic [BUF_W-1:0] buf_o,
  output logic [EVT_W-1:0] evt_bits_o
);
  logic [LINES-1:0] pins_raw, pins_s;
  logic sda_s, scl_s, sda_q;
  logic accept, active;
  logic cnt_load, cnt_busy, tout;
  logic done_p, bcol_p, start_p;

  assign pins_raw[LINE_SDA] = sda_in_i;
  assign pins_raw[LINE_SCL] = scl_in_i;

  rs_pin_sync #(.STAGES(SYNC_STAGES), .W(LINES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pins_raw),
    .q_o (pins_s)
  );

  assign sda_s = pins_s[LINE_SDA];
  assign scl_s = pins_s[LINE_SCL];

  rs_baud_cnt #(.W(RLD_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .load_i (cnt_load),
    .val_i  (reload_i),
    .busy_o (cnt_busy),
    .tout_o (tout)
  );

  assign accept = req_set_i && !req_o && !other_busy_i;

  rs_seq_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start_i    (accept),
    .sda_s_i    (sda_s),
    .scl_s_i    (scl_s),
    .tout_i     (tout),
    .cnt_busy_i (cnt_busy),
    .cnt_load_o (cnt_load),
    .done_o     (done_p),
    .bcol_o     (bcol_p),
    .active_o   (active),
    .sda_drv_o  (sda_drv_o),
    .scl_drv_o  (scl_drv_o)
  );

  assign start_p = sda_q && !sda_s && scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_q       <= 1'b1;
      req_o       <= 1'b0;
      start_det_o <= 1'b0;
      done_irq_o  <= 1'b0;
      wcol_o      <= 1'b0;
      bcol_o      <= 1'b0;
      buf_o       <= '0;
      evt_bits_o  <= '0;
    end else begin
      sda_q <= sda_s;
      if (accept)               req_o <= 1'b1;
      else if (done_p || bcol_p) req_o <= 1'b0;

      if (flag_clr_i) begin
        start_det_o <= 1'b0;
        done_irq_o  <= 1'b0;
        wcol_o      <= 1'b0;
        bcol_o      <= 1'b0;
      end
      if (start_p) start_det_o <= 1'b1;
      if (done_p)  done_irq_o  <= 1'b1;
      if (bcol_p)  bcol_o      <= 1'b1;

      if (buf_wr_i) begin
        if (active) wcol_o <= 1'b1;
        else        buf_o  <= buf_wdata_i;
      end
      if (evt_wr_i && !active) evt_bits_o <= evt_wdata_i;
    end
  end
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int BUF_W = 8,
  parameter int EVT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_set_i,
  input logic             other_busy_i,
  input logic             buf_wr_i,
  input logic             sda_drv_o,
  input logic             scl_drv_o,
  input logic             req_o,
  input logic             done_irq_o,
  input logic             wcol_o,
  input logic             bcol_o,
  input logic [BUF_W-1:0] buf_o,
  input logic [EVT_W-1:0] evt_bits_o
);
  p_busy_ignore_r1: assert property (@(posedge clk) disable iff (rst)
    (req_set_i && other_busy_i && !req_o) |=> !req_o);

  p_first_scl_r2: assert property (@(posedge clk) disable iff (rst)
    (req_set_i && !other_busy_i && !req_o) |=> (req_o && scl_drv_o));

  p_scl_rel_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(scl_drv_o) && req_o) |-> !sda_drv_o);

  p_end_state_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(done_irq_o) |-> (sda_drv_o && !scl_drv_o && !req_o));

  p_done_src_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(done_irq_o) |-> $past(req_o));

  p_wcol_r8: assert property (@(posedge clk) disable iff (rst)
    (buf_wr_i && req_o) |=> (wcol_o && $stable(buf_o)));

  p_bcol_rel_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(bcol_o) |-> (!sda_drv_o && !scl_drv_o && !req_o));

  p_evt_lock_r11: assert property (@(posedge clk) disable iff (rst)
    req_o |=> $stable(evt_bits_o));
endmodule

bind i2c_rstart_seq rs_checker #(.BUF_W(BUF_W), .EVT_W(EVT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_set_i    (req_set_i),
  .other_busy_i (other_busy_i),
  .buf_wr_i     (buf_wr_i),
  .sda_drv_o    (sda_drv_o),
  .scl_drv_o    (scl_drv_o),
  .req_o        (req_o),
  .done_irq_o   (done_irq_o),
  .wcol_o       (wcol_o),
  .bcol_o       (bcol_o),
  .buf_o        (buf_o),
  .evt_bits_o   (evt_bits_o)
);

// File: tb/i2c_rstart_seq_bench.sv
module i2c_rstart_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_set = 1'b0, other_busy = 1'b0;
  logic [6:0] reload = 7'd3;
  logic       buf_wr = 1'b0, evt_wr = 1'b0, flag_clr = 1'b0;
  logic [7:0] buf_wdata = '0;
  logic [3:0] evt_wdata = '0;
  logic       ext_sda_low = 1'b0, ext_scl_low = 1'b0;
  logic       sda_drv, scl_drv, req, start_det, done_irq, wcol, bcol;
  logic [7:0] buf_q;
  logic [3:0] evt_q;
  logic       sda_line, scl_line;

  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  bit ended = 0;
  int exp_kind_q[$];
  int exp_cyc_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign sda_line = !sda_drv && !ext_sda_low;
  assign scl_line = !scl_drv && !ext_scl_low;

  i2c_rstart_seq u_i2c_rstart_seq (
    .clk(clk), .rst(rst), .req_set_i(req_set), .other_busy_i(other_busy),
    .reload_i(reload), .sda_in_i(sda_line), .scl_in_i(scl_line),
    .buf_wr_i(buf_wr), .buf_wdata_i(buf_wdata), .evt_wr_i(evt_wr),
    .evt_wdata_i(evt_wdata), .flag_clr_i(flag_clr), .sda_drv_o(sda_drv),
    .scl_drv_o(scl_drv), .req_o(req), .start_det_o(start_det),
    .done_irq_o(done_irq), .wcol_o(wcol), .bcol_o(bcol), .buf_o(buf_q),
    .evt_bits_o(evt_q)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic at_cyc(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic start_seq(input int rl, input int kind, input int lat, output int t0);
    reload  = rl[6:0];
    req_set = 1'b1;
    t0      = cyc + 1;
    exp_kind_q.push_back(kind);
    exp_cyc_q.push_back(t0 + lat);
    @(negedge clk);
    req_set = 1'b0;
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  // monitor: pops expected completion/collision records (R4, R9, R10)
  logic done_prev = 1'b0, bcol_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if ((done_irq && !done_prev) || (bcol && !bcol_prev)) begin
        if (exp_kind_q.size() == 0) begin
          check("R7 unexpected completion event", 1, 0);
        end else begin
          int k, c;
          k = exp_kind_q.pop_front();
          c = exp_cyc_q.pop_front();
          check(k == 0 ? "R4 done latency" : "R9/R10 collision latency", cyc, c);
          check("R7 event kind (0 done, 1 collision)", bcol && !bcol_prev ? 1 : 0, k);
        end
      end
      done_prev <= done_irq;
      bcol_prev <= bcol;
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    int t0, r;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    check("R13 sda_drv", sda_drv, 0);
    check("R13 scl_drv", scl_drv, 0);
    check("R13 req", req, 0);
    check("R13 flags", {start_det, done_irq, wcol, bcol}, 0);
    check("R13 buf", buf_q, 0);
    check("R13 evt", evt_q, 0);

    // R8 idle write loads buffer
    buf_wr = 1'b1; buf_wdata = 8'h11;
    @(negedge clk);
    buf_wr = 1'b0;
    check("R8 idle write", buf_q, 8'h11);
    check("R8 no wcol idle", wcol, 0);

    // R1 request ignored when another event is busy
    other_busy = 1'b1; req_set = 1'b1;
    @(negedge clk);
    req_set = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 req ignored", req, 0);
    check("R1 scl undriven", scl_drv, 0);
    other_busy = 1'b0;

    // sequence 1, reload 3, normal
    r = 3;
    start_seq(r, 0, 3*r + 9, t0);
    check("R2 req set", req, 1);
    check("R2 scl driven low", scl_drv, 1);
    at_cyc(t0 + 4);
    evt_wr = 1'b1; evt_wdata = 4'hF;
    @(negedge clk);
    evt_wr = 1'b0;
    check("R11 evt write blocked", evt_q, 0);
    at_cyc(t0 + r + 3);
    check("R3 scl still low", scl_drv, 1);
    at_cyc(t0 + r + 4);
    check("R3 scl released", scl_drv, 0);
    check("R3 sda released", sda_drv, 0);
    at_cyc(t0 + 2*r + 10);
    check("R6 start not yet", start_det, 0);
    at_cyc(t0 + 2*r + 11);
    check("R6 start detected", start_det, 1);
    check("R7 no done at start detect", done_irq, 0);
    at_cyc(t0 + 3*r + 8);
    check("R7 no done before final timeout", done_irq, 0);
    buf_wr = 1'b1; buf_wdata = 8'hA5;
    @(negedge clk);
    check("R8 wcol on completion edge", wcol, 1);
    check("R8 buffer unchanged", buf_q, 8'h11);
    check("R7 done on final timeout", done_irq, 1);
    check("R5 sda held low", sda_drv, 1);
    check("R5 scl released", scl_drv, 0);
    check("R5 req cleared", req, 0);
    buf_wdata = 8'h3C; evt_wr = 1'b1; evt_wdata = 4'h5;
    @(negedge clk);
    buf_wr = 1'b0; evt_wr = 1'b0;
    check("R8 write after completion", buf_q, 8'h3C);
    check("R11 evt write when idle", evt_q, 5);

    clear_flags();
    check("R12 flags cleared", {start_det, done_irq, wcol, bcol}, 0);

    // sequence 2, reload 4, SDA left low by sequence 1
    r = 4;
    start_seq(r, 0, 3*r + 9, t0);
    at_cyc(t0 + 2);
    check("R14 sda still held", sda_drv, 1);
    at_cyc(t0 + 3);
    check("R14 sda released after scl seen low", sda_drv, 0);
    at_cyc(t0 + 3*r + 12);
    check("R5 sda held after seq 2", sda_drv, 1);
    clear_flags();

    // sequence 3, reload 3, SDA pulled low at SCL release
    r = 3;
    start_seq(r, 1, r + 7, t0);
    at_cyc(t0 + r + 4);
    ext_sda_low = 1'b1;
    at_cyc(t0 + r + 6);
    check("R9 no collision yet", bcol, 0);
    at_cyc(t0 + r + 7);
    check("R9 bus collision", bcol, 1);
    check("R9 drives released", {sda_drv, scl_drv}, 0);
    check("R9 req cleared", req, 0);
    ext_sda_low = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 no done after collision", done_irq, 0);
    clear_flags();
    repeat (3) @(negedge clk);

    // sequence 4, reload 6, SCL pulled low in the high hold
    r = 6;
    start_seq(r, 1, r + 11, t0);
    at_cyc(t0 + r + 8);
    ext_scl_low = 1'b1;
    at_cyc(t0 + r + 11);
    check("R10 bus collision", bcol, 1);
    check("R10 drives released", {sda_drv, scl_drv}, 0);
    check("R10 req cleared", req, 0);
    ext_scl_low = 1'b0;
    repeat (3 * r) @(negedge clk);
    check("R10 no done after collision", done_irq, 0);

    repeat (5) @(negedge clk);
    check("R4 all expected events seen", exp_kind_q.size(), 0);
    finish_run();
  end
endmodule